// File: doc/BRIEF.md
# Large-Page NAND Command Sequencer

This block turns one command request into the ordered list of latch cycles that a large-page NAND device (page above 512 bytes) expects. A request carries an opcode, an optional column and an optional page address. The block emits one command or address byte per clock, with its command-latch or address-latch qualifier, and keeps chip select asserted for the whole sequence. Where the device needs a second-stage confirm command, the block appends it. An out-of-band read request becomes a normal page read whose column points past the data area.

When the sequence is finished the block raises a one-cycle completion strobe. With it come two indications. One says whether the host must now wait for the device's ready line. The other asks for a column-change settling delay and gives its length in clocks. Strobe timing on the device pins and the data transfer phase belong to the surrounding controller.

Top module: `nand_lp_seq`

## Requirements
- R1: After reset the block is idle: `ready_o`=1, `lat_vld_o`=0, `chip_sel_o`=0, `done_o`=0.
- R2: A request is accepted on a clock edge where `req_i` and `ready_o` are both high. From the next cycle the block emits one latch cycle per clock on `lat_vld_o`. The first is the opcode with `cle_o`=1 and `ale_o`=0. Every address byte has `ale_o`=1 and `cle_o`=0.
- R3: A present column is sent as two address bytes, low byte first. Only the low byte is sent for the byte-only opcodes 0x90, 0xEC, 0xEE and 0xEF.
- R4: With `bus16_i`=1 the column is shifted right by one before it is sent, except for the byte-only opcodes.
- R5: A present page address follows the column as two bytes, low first. With `row3_i`=1 a third, most significant byte follows.
- R6: Opcode 0x50 (out-of-band read) is sent as opcode 0x00 with PAGE_BYTES added to the column. A missing column counts as 0, so the column is always sent.
- R7: Opcode 0x00 with any address is followed by confirm command 0x30, and the completion strobe then asks for a ready wait. Opcode 0x00 with no address emits only the opcode and asks for no wait.
- R8: Opcode 0x05 is followed by confirm command 0xE0. At completion it asks for the settling delay and no ready wait.
- R9: Opcode 0x85 emits no confirm. At completion it asks for the settling delay and no ready wait.
- R10: The settling delay length is `ccs_cfg_cyc_i` when `ccs_cfg_vld_i`=1, and otherwise 500 ns expressed in clocks (25 at 50 MHz). No delay is requested when `ccs_en_i`=0.
- R11: Opcodes 0x10, 0x15, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF ask for no ready wait. All other opcodes, such as 0xFF and 0xEE, ask for one.
- R12: Chip select stays high from the first latch cycle through the completion strobe, which lasts one cycle. Requests that arrive while the block is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a command sequence |
| ready_o | output | 1 | Idle, a request will be accepted |
| opcode_i | input | 8 | Command opcode |
| col_vld_i | input | 1 | Column present |
| col_i | input | 16 | Column address in bytes |
| page_vld_i | input | 1 | Page address present |
| page_i | input | 24 | Page (row) address |
| bus16_i | input | 1 | Device has a 16-bit data bus |
| row3_i | input | 1 | Page address uses three bytes |
| ccs_en_i | input | 1 | Settling delay after column change enabled |
| ccs_cfg_vld_i | input | 1 | Configured minimum delay is defined |
| ccs_cfg_cyc_i | input | 16 | Configured minimum delay in clocks |
| lat_vld_o | output | 1 | A latch cycle is presented this clock |
| lat_data_o | output | 8 | Byte of the latch cycle |
| cle_o | output | 1 | Command latch qualifier |
| ale_o | output | 1 | Address latch qualifier |
| chip_sel_o | output | 1 | Chip select, active high |
| done_o | output | 1 | One-cycle completion strobe |
| wait_rdy_o | output | 1 | With done_o: host must wait for ready |
| ccs_req_o | output | 1 | With done_o: settling delay requested |
| ccs_cyc_o | output | 16 | Settling delay length in clocks |

## Verification
The main function is tried with page reads that have both addresses, only a page, only a column, or none, with two-byte and three-byte rows. These cases separate the column, page and confirm counts. Out-of-band reads with and without a column, on both bus widths, show whether the page-size offset is added before the halving. A byte-only opcode on the 16-bit bus shows that both the halving and the high byte are skipped. Column-change commands with the delay enabled, disabled and configured separate the delay source from the confirm command, and a request held during a busy sequence shows that it is ignored.

// File: rtl/nand_lp_pkg.sv
package nand_lp_pkg;
  localparam int MAX_LAT = 7;  // opcode + 2 column + 3 row + confirm

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic [7:0] data;
  } lat_t;

  localparam logic [7:0] OP_READ0      = 8'h00;
  localparam logic [7:0] OP_READSTART  = 8'h30;
  localparam logic [7:0] OP_OOB        = 8'h50;
  localparam logic [7:0] OP_RNDOUT     = 8'h05;
  localparam logic [7:0] OP_RNDOUT_CFM = 8'hE0;
  localparam logic [7:0] OP_RNDIN      = 8'h85;
  localparam logic [7:0] OP_SEQIN      = 8'h80;
  localparam logic [7:0] OP_PROG       = 8'h10;
  localparam logic [7:0] OP_CPROG      = 8'h15;
  localparam logic [7:0] OP_ERASE1     = 8'h60;
  localparam logic [7:0] OP_ERASE2     = 8'hD0;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_READID     = 8'h90;
  localparam logic [7:0] OP_PARAM      = 8'hEC;
  localparam logic [7:0] OP_GETFEAT    = 8'hEE;
  localparam logic [7:0] OP_SETFEAT    = 8'hEF;

  function automatic logic is_byte_op(input logic [7:0] op);
    return (op == OP_READID) || (op == OP_PARAM) ||
           (op == OP_GETFEAT) || (op == OP_SETFEAT);
  endfunction
endpackage

// File: rtl/nand_lp_plan.sv
module nand_lp_plan
  import nand_lp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int COL_W      = 16,
  parameter int ROW_W      = 24
) (
  input  logic [7:0]       opcode_i,
  input  logic             col_vld_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             page_vld_i,
  input  logic [ROW_W-1:0] page_i,
  input  logic             bus16_i,
  input  logic             row3_i,
  output lat_t             ent_o [MAX_LAT],
  output logic [3:0]       n_o,
  output logic             wait_o,
  output logic             ccs_o
);
  localparam logic [COL_W-1:0] PAGE_OFS = COL_W'(PAGE_BYTES);

  logic             oob;
  logic [7:0]       op_eff;
  logic             has_col;
  logic [COL_W-1:0] col_a;
  logic             byte_op;
  logic             has_addr;

  always_comb begin
    oob      = (opcode_i == OP_OOB);
    op_eff   = oob ? OP_READ0 : opcode_i;
    has_col  = col_vld_i || oob;
    col_a    = col_vld_i ? col_i : '0;
    if (oob) col_a = col_a + PAGE_OFS;
    byte_op  = is_byte_op(op_eff);
    if (bus16_i && !byte_op) col_a = col_a >> 1;
    has_addr = has_col || page_vld_i;

    for (int i = 0; i < MAX_LAT; i++) ent_o[i] = '0;
    n_o = 4'd0;
    ent_o[n_o[2:0]] = '{cle: 1'b1, ale: 1'b0, data: op_eff};
    n_o = n_o + 4'd1;
    if (has_col) begin
      ent_o[n_o[2:0]] = '{cle: 1'b0, ale: 1'b1, data: col_a[7:0]};
      n_o = n_o + 4'd1;
      if (!byte_op) begin
        ent_o[n_o[2:0]] = '{cle: 1'b0, ale: 1'b1, data: col_a[15:8]};
        n_o = n_o + 4'd1;
      end
    end
    if (page_vld_i) begin
      ent_o[n_o[2:0]] = '{cle: 1'b0, ale: 1'b1, data: page_i[7:0]};
      n_o = n_o + 4'd1;
      ent_o[n_o[2:0]] = '{cle: 1'b0, ale: 1'b1, data: page_i[15:8]};
      n_o = n_o + 4'd1;
      if (row3_i) begin
        ent_o[n_o[2:0]] = '{cle: 1'b0, ale: 1'b1, data: page_i[23:16]};
        n_o = n_o + 4'd1;
      end
    end
    if (op_eff == OP_READ0 && has_addr) begin
      ent_o[n_o[2:0]] = '{cle: 1'b1, ale: 1'b0, data: OP_READSTART};
      n_o = n_o + 4'd1;
    end else if (op_eff == OP_RNDOUT) begin
      ent_o[n_o[2:0]] = '{cle: 1'b1, ale: 1'b0, data: OP_RNDOUT_CFM};
      n_o = n_o + 4'd1;
    end

    unique case (op_eff)
      OP_PROG, OP_CPROG, OP_ERASE1, OP_ERASE2, OP_SEQIN,
      OP_STATUS, OP_READID, OP_SETFEAT, OP_RNDOUT, OP_RNDIN: wait_o = 1'b0;
      OP_READ0: wait_o = has_addr;
      default:  wait_o = 1'b1;
    endcase
    ccs_o = (op_eff == OP_RNDOUT) || (op_eff == OP_RNDIN);
  end
endmodule

// File: rtl/nand_lp_ccs.sv
module nand_lp_ccs #(
  parameter int CLK_MHZ    = 50,
  parameter int CCS_DEF_NS = 500,
  parameter int CCS_W      = 16
) (
  input  logic             need_i,
  input  logic             en_i,
  input  logic             cfg_vld_i,
  input  logic [CCS_W-1:0] cfg_cyc_i,
  output logic             req_o,
  output logic [CCS_W-1:0] cyc_o
);
  localparam int DEF_CYC_I = (CCS_DEF_NS * CLK_MHZ + 999) / 1000;
  localparam logic [CCS_W-1:0] DEF_CYC = CCS_W'(DEF_CYC_I);

  assign req_o = need_i && en_i;
  assign cyc_o = cfg_vld_i ? cfg_cyc_i : DEF_CYC;
endmodule

// File: rtl/nand_lp_emit.sv
module nand_lp_emit
  import nand_lp_pkg::*;
#(
  parameter int CCS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  lat_t             ent_i [MAX_LAT],
  input  logic [3:0]       n_i,
  input  logic             wait_i,
  input  logic             ccs_i,
  input  logic [CCS_W-1:0] ccs_cyc_i,
  output logic             idle_o,
  output logic             lat_vld_o,
  output lat_t             lat_o,
  output logic             chip_sel_o,
  output logic             done_o,
  output logic             wait_o,
  output logic             ccs_o,
  output logic [CCS_W-1:0] ccs_cyc_o
);
  typedef enum logic [1:0] {S_IDLE, S_EMIT, S_FIN} st_t;

  st_t              st_q;
  lat_t             ent_q [MAX_LAT];
  logic [2:0]       idx_q;
  logic [2:0]       last_q;
  logic             wait_q, ccs_q;
  logic [CCS_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      wait_q <= 1'b0;
      ccs_q  <= 1'b0;
      cyc_q  <= '0;
      for (int i = 0; i < MAX_LAT; i++) ent_q[i] <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_EMIT;
          idx_q  <= '0;
          last_q <= 3'(n_i - 4'd1);
          wait_q <= wait_i;
          ccs_q  <= ccs_i;
          cyc_q  <= ccs_cyc_i;
          for (int i = 0; i < MAX_LAT; i++) ent_q[i] <= ent_i[i];
        end
        S_EMIT: if (idx_q == last_q) st_q <= S_FIN;
                else idx_q <= idx_q + 3'd1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == S_IDLE);
  assign lat_vld_o  = (st_q == S_EMIT);
  assign lat_o      = ent_q[idx_q];
  assign chip_sel_o = (st_q != S_IDLE);
  assign done_o     = (st_q == S_FIN);
  assign wait_o     = done_o && wait_q;
  assign ccs_o      = done_o && ccs_q;
  assign ccs_cyc_o  = cyc_q;

  assert_cle_ale_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_vld_o |-> !(lat_o.cle && lat_o.ale));
  assert_first_is_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_vld_o && !$past(lat_vld_o)) |-> lat_o.cle);
  assert_done_one_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && idle_o));
  assert_ccs_no_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccs_o |-> !wait_o);
endmodule

// File: rtl/nand_lp_seq.sv
module nand_lp_seq
  import nand_lp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int COL_W      = 16,
  parameter int ROW_W      = 24,
  parameter int CLK_MHZ    = 50,
  parameter int CCS_DEF_NS = 500,
  parameter int CCS_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             ready_o,
  input  logic [7:0]       opcode_i,
  input  logic             col_vld_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             page_vld_i,
  input  logic [ROW_W-1:0] page_i,
  input  logic             bus16_i,
  input  logic             row3_i,
  input  logic             ccs_en_i,
  input  logic             ccs_cfg_vld_i,
  input  logic [CCS_W-1:0] ccs_cfg_cyc_i,
  output logic             lat_vld_o,
  output logic [7:0]       lat_data_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             chip_sel_o,
  output logic             done_o,
  output logic             wait_rdy_o,
  output logic             ccs_req_o,
  output logic [CCS_W-1:0] ccs_cyc_o
);
  lat_t             ent [MAX_LAT];
  logic [3:0]       n;
  logic             plan_wait, plan_ccs, ccs_need;
  logic [CCS_W-1:0] ccs_len;
  lat_t             lat;
  logic             idle;

  nand_lp_plan #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .ROW_W(ROW_W)) u_plan (
    .opcode_i(opcode_i), .col_vld_i(col_vld_i), .col_i(col_i),
    .page_vld_i(page_vld_i), .page_i(page_i), .bus16_i(bus16_i),
    .row3_i(row3_i), .ent_o(ent), .n_o(n), .wait_o(plan_wait), .ccs_o(plan_ccs)
  );

  nand_lp_ccs #(.CLK_MHZ(CLK_MHZ), .CCS_DEF_NS(CCS_DEF_NS), .CCS_W(CCS_W)) u_ccs (
    .need_i(plan_ccs), .en_i(ccs_en_i), .cfg_vld_i(ccs_cfg_vld_i),
    .cfg_cyc_i(ccs_cfg_cyc_i), .req_o(ccs_need), .cyc_o(ccs_len)
  );

  nand_lp_emit #(.CCS_W(CCS_W)) u_emit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(req_i && idle),
    .ent_i(ent), .n_i(n), .wait_i(plan_wait), .ccs_i(ccs_need),
    .ccs_cyc_i(ccs_len), .idle_o(idle), .lat_vld_o(lat_vld_o), .lat_o(lat),
    .chip_sel_o(chip_sel_o), .done_o(done_o), .wait_o(wait_rdy_o),
    .ccs_o(ccs_req_o), .ccs_cyc_o(ccs_cyc_o)
  );

  assign ready_o    = idle;
  assign lat_data_o = lat.data;
  assign cle_o      = lat.cle;
  assign ale_o      = lat.ale;

  assert_sel_during_lat_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_vld_o || done_o) |-> chip_sel_o);
  assert_lat_follows_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (lat_vld_o && cle_o));
endmodule

// File: tb/nand_lp_seq_tb.sv
module nand_lp_seq_tb;
  localparam int NV = 20;
  localparam logic [9:0] Z = 10'h000;

  function automatic logic [9:0] C(input logic [7:0] b); return {2'b10, b}; endfunction
  function automatic logic [9:0] A(input logic [7:0] b); return {2'b01, b}; endfunction
  function automatic logic [69:0] sq(input logic [9:0] a, b, c, d, e, f, g);
    return {g, f, e, d, c, b, a};
  endfunction

  typedef struct packed {
    logic [7:0]  op;
    logic        colv;
    logic [15:0] col;
    logic        pgv;
    logic [23:0] pg;
    logic        b16;
    logic        r3;
    logic [3:0]  n;
    logic [69:0] seq;
    logic        w;
    logic        c;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{8'h00,1'b1,16'h0123,1'b1,24'h045678,1'b0,1'b0,4'd6,sq(C(8'h00),A(8'h23),A(8'h01),A(8'h78),A(8'h56),C(8'h30),Z),1'b1,1'b0},
    '{8'h00,1'b1,16'h0123,1'b1,24'h045678,1'b0,1'b1,4'd7,sq(C(8'h00),A(8'h23),A(8'h01),A(8'h78),A(8'h56),A(8'h04),C(8'h30)),1'b1,1'b0},
    '{8'h00,1'b0,16'h0000,1'b0,24'h000000,1'b0,1'b0,4'd1,sq(C(8'h00),Z,Z,Z,Z,Z,Z),1'b0,1'b0},
    '{8'h50,1'b1,16'h0010,1'b1,24'h000012,1'b0,1'b0,4'd6,sq(C(8'h00),A(8'h10),A(8'h08),A(8'h12),A(8'h00),C(8'h30),Z),1'b1,1'b0},
    '{8'h50,1'b1,16'h0010,1'b1,24'h000012,1'b1,1'b0,4'd6,sq(C(8'h00),A(8'h08),A(8'h04),A(8'h12),A(8'h00),C(8'h30),Z),1'b1,1'b0},
    '{8'h00,1'b1,16'h0246,1'b1,24'h000001,1'b1,1'b0,4'd6,sq(C(8'h00),A(8'h23),A(8'h01),A(8'h01),A(8'h00),C(8'h30),Z),1'b1,1'b0},
    '{8'h05,1'b1,16'h0345,1'b0,24'h000000,1'b0,1'b0,4'd4,sq(C(8'h05),A(8'h45),A(8'h03),C(8'hE0),Z,Z,Z),1'b0,1'b1},
    '{8'h85,1'b1,16'h0010,1'b0,24'h000000,1'b0,1'b0,4'd3,sq(C(8'h85),A(8'h10),A(8'h00),Z,Z,Z,Z),1'b0,1'b1},
    '{8'h90,1'b1,16'h0020,1'b0,24'h000000,1'b1,1'b0,4'd2,sq(C(8'h90),A(8'h20),Z,Z,Z,Z,Z),1'b0,1'b0},
    '{8'h80,1'b1,16'h0005,1'b1,24'h0A0B0C,1'b0,1'b1,4'd6,sq(C(8'h80),A(8'h05),A(8'h00),A(8'h0C),A(8'h0B),A(8'h0A),Z),1'b0,1'b0},
    '{8'h60,1'b0,16'h0000,1'b1,24'h030201,1'b0,1'b1,4'd4,sq(C(8'h60),A(8'h01),A(8'h02),A(8'h03),Z,Z,Z),1'b0,1'b0},
    '{8'h70,1'b0,16'h0000,1'b0,24'h000000,1'b0,1'b0,4'd1,sq(C(8'h70),Z,Z,Z,Z,Z,Z),1'b0,1'b0},
    '{8'hFF,1'b0,16'h0000,1'b0,24'h000000,1'b0,1'b0,4'd1,sq(C(8'hFF),Z,Z,Z,Z,Z,Z),1'b1,1'b0},
    '{8'h10,1'b0,16'h0000,1'b0,24'h000000,1'b0,1'b0,4'd1,sq(C(8'h10),Z,Z,Z,Z,Z,Z),1'b0,1'b0},
    '{8'hEE,1'b1,16'h0001,1'b0,24'h000000,1'b0,1'b0,4'd2,sq(C(8'hEE),A(8'h01),Z,Z,Z,Z,Z),1'b1,1'b0},
    '{8'h00,1'b0,16'h0000,1'b1,24'h001234,1'b0,1'b0,4'd4,sq(C(8'h00),A(8'h34),A(8'h12),C(8'h30),Z,Z,Z),1'b1,1'b0},
    '{8'h50,1'b0,16'h0000,1'b1,24'h000001,1'b0,1'b0,4'd6,sq(C(8'h00),A(8'h00),A(8'h08),A(8'h01),A(8'h00),C(8'h30),Z),1'b1,1'b0},
    '{8'h15,1'b0,16'h0000,1'b0,24'h000000,1'b0,1'b0,4'd1,sq(C(8'h15),Z,Z,Z,Z,Z,Z),1'b0,1'b0},
    '{8'hEF,1'b1,16'h0080,1'b0,24'h000000,1'b1,1'b0,4'd2,sq(C(8'hEF),A(8'h80),Z,Z,Z,Z,Z),1'b0,1'b0},
    '{8'hD0,1'b0,16'h0000,1'b0,24'h000000,1'b0,1'b0,4'd1,sq(C(8'hD0),Z,Z,Z,Z,Z,Z),1'b0,1'b0}
  };

  string tags [NV] = '{
    "R2 R3 R5 R7", "R5 R7", "R7", "R6 R7", "R4 R6", "R4 R7", "R8 R10", "R9 R10",
    "R3 R4 R11", "R5 R11", "R5 R11", "R11", "R11", "R11", "R3 R11", "R5 R7",
    "R6", "R11", "R3 R4 R11", "R11"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  opcode = '0;
  logic        col_vld = 1'b0;
  logic [15:0] col = '0;
  logic        page_vld = 1'b0;
  logic [23:0] page = '0;
  logic        bus16 = 1'b0;
  logic        row3 = 1'b0;
  logic        ccs_en = 1'b1;
  logic        ccs_cfg_vld = 1'b0;
  logic [15:0] ccs_cfg_cyc = '0;
  logic        ready, lat_vld, cle, ale, chip_sel, done, wait_rdy, ccs_req;
  logic [7:0]  lat_data;
  logic [15:0] ccs_cyc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nand_lp_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready),
    .opcode_i(opcode), .col_vld_i(col_vld), .col_i(col),
    .page_vld_i(page_vld), .page_i(page), .bus16_i(bus16), .row3_i(row3),
    .ccs_en_i(ccs_en), .ccs_cfg_vld_i(ccs_cfg_vld), .ccs_cfg_cyc_i(ccs_cfg_cyc),
    .lat_vld_o(lat_vld), .lat_data_o(lat_data), .cle_o(cle), .ale_o(ale),
    .chip_sel_o(chip_sel), .done_o(done), .wait_rdy_o(wait_rdy),
    .ccs_req_o(ccs_req), .ccs_cyc_o(ccs_cyc)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // hold: keep req high with another opcode while busy (R12)
  task automatic run(input vec_t v, input string tag, input logic en, cfgv,
                     input logic [15:0] cfgc, input logic hold);
    logic [9:0] got [7];
    int cnt = 0;
    logic sel_ok = 1'b1;
    @(negedge clk);
    opcode = v.op; col_vld = v.colv; col = v.col; page_vld = v.pgv; page = v.pg;
    bus16 = v.b16; row3 = v.r3; ccs_en = en; ccs_cfg_vld = cfgv; ccs_cfg_cyc = cfgc;
    req = 1'b1;
    @(negedge clk);
    if (hold) opcode = 8'h70; else req = 1'b0;
    for (int g = 0; g < 12 && !done; g++) begin
      if (lat_vld && cnt < 7) got[cnt] = {cle, ale, lat_data};
      if (lat_vld) cnt++;
      if (!chip_sel) sel_ok = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    chk(done, {tag, " done"}, 32'(done), 1);
    chk(cnt == int'(v.n), {tag, " count"}, 32'(cnt), 32'(v.n));
    for (int k = 0; k < 7; k++)
      if (k < cnt && k < int'(v.n))
        chk(got[k] == v.seq[k*10 +: 10], {tag, " latch"}, 32'(got[k]), 32'(v.seq[k*10 +: 10]));
    chk(sel_ok && chip_sel, {tag, " R12 chip select"}, 32'(sel_ok), 1);
    chk(wait_rdy == v.w, {tag, " wait"}, 32'(wait_rdy), 32'(v.w));
    chk(ccs_req == (v.c && en), {tag, " delay req"}, 32'(ccs_req), 32'(v.c && en));
    if (v.c && en)
      chk(ccs_cyc == (cfgv ? cfgc : 16'd25), {tag, " R10 delay len"}, 32'(ccs_cyc),
          32'(cfgv ? cfgc : 16'd25));
    @(negedge clk);
    chk(ready && !lat_vld && !done, {tag, " R12 back idle"}, 32'({ready, lat_vld, done}), 32'b100);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready && !lat_vld && !chip_sel && !done, "R1 reset state",
        32'({ready, lat_vld, chip_sel, done}), 32'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !lat_vld, "R1 after release", 32'({ready, lat_vld}), 32'b10);

    for (int i = 0; i < NV; i++) run(VT[i], tags[i], 1'b1, 1'b0, 16'd0, 1'b0);

    // R10 delay disabled
    run(VT[6], "R10 disabled", 1'b0, 1'b0, 16'd0, 1'b0);
    // R10 configured length
    run(VT[7], "R10 configured", 1'b1, 1'b1, 16'd7, 1'b0);
    // R12 request held while busy is ignored
    run(VT[1], "R12 busy hold", 1'b1, 1'b0, 16'd0, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule